// File: doc/BRIEF.md
# PLL Unlock Detect Flag

This block watches the two active-low request outputs of a phase comparator (an "up" request and a "down" request) and keeps a sticky flag that records whether the loop has looked unlocked. The loop counts as unlocked whenever either request is low. The requests are not acted on directly. They pass through a two-flop synchroniser, and the flag is updated only on a one-clock strobe. That strobe is derived from each rising edge of the reference-frequency clock, so the loop is judged once per reference period.

Software reads the flag as bit 0 of a read-only status word on a simple read strobe bus. All other bits read as zero. A read clears the flag. A flag that is set again in the same clock as the read stays set, so no unlock event is lost. The flag clears on read and is only updated once per reference period. Software must therefore leave at least one reference period between reads, or a read may see a stale zero.

The flag controller is a two-state machine. Its states are `FLAG_CLEAR` and `FLAG_SET`, and it has these transitions:
- **set** (`FLAG_CLEAR`→`FLAG_SET`): the strobe fires while the loop is unlocked.
- **clear** (`FLAG_SET`→`FLAG_CLEAR`): a read occurs with no set in that clock.
- **hold**: every other case keeps the current state.

The reference edge detector is a second two-state machine. Its states are `REF_LOW` and `REF_HIGH`, and it has these transitions:
- **rise** (`REF_LOW`→`REF_HIGH`): the synchronised reference goes high. The strobe is emitted on this transition.
- **fall** (`REF_HIGH`→`REF_LOW`): the synchronised reference goes low.

A synchronous reset puts both machines in their first state.

Top module: `pll_unlock_monitor`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge) the flag is clear, and a read returns all zeros.
- R2: If `up_req_n` is low at a reference strobe, the flag is set.
- R3: If `dn_req_n` is low at a reference strobe, the flag is set. With both requests high, the flag stays clear.
- R4: The flag is sticky: once set, it stays set until a read, even if both requests return high.
- R5: A read (`rd_en` high for one clock) returns the flag in bit 0 of `rd_data`. The flag is clear from the following clock, unless it is set again in that same clock.
- R6: Bits `DATA_W-1` down to 1 of `rd_data` always read as zero.
- R7: When a set condition and a read fall in the same clock, the set wins and the flag remains set.
- R8: The requests are sampled only on the one-clock strobe that follows each rising edge of `ref_clk_in`. Each request passes through two synchroniser flops first. An unlock pulse that lies wholly between strobes leaves the flag clear.
- R9: `rd_data` is all zeros whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_clk_in | input | 1 | Reference-frequency clock; its rising edges define sampling points |
| up_req_n | input | 1 | Phase comparator up request, active low |
| dn_req_n | input | 1 | Phase comparator down request, active low |
| rd_en | input | 1 | Status register read strobe, one clock per read |
| rd_data | output | DATA_W | Status word; bit 0 is the unlock flag |

## Verification
A read-clear and a strobe-driven set can fall in the same clock. This is the case where losing an unlock event would go unnoticed.

The bench produces the reference clock itself, in step with the system clock. It therefore knows that the strobe is high in the second clock after the edge at which the new reference level is first captured, and it raises `rd_en` in exactly that clock while the loop is unlocked. In the same clock it returns both requests high, so that no later strobe can set the flag again. A further, properly spaced read must then still return 1, and the read after that must return 0.

// File: rtl/unl_pkg.sv
package unl_pkg;

    // Sticky unlock flag controller states
    typedef enum logic {
        FLAG_CLEAR = 1'b0,
        FLAG_SET   = 1'b1
    } flag_state_t;

    // Reference clock edge detector states
    typedef enum logic {
        REF_LOW  = 1'b0,
        REF_HIGH = 1'b1
    } ref_state_t;

endpackage

// File: rtl/unl_sync.sv
module unl_sync #(
    parameter int          WIDTH   = 1,
    parameter int          STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);

    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stg[s] <= {WIDTH{RST_VAL}};
                end else if (s == 0) begin
                    stg[s] <= d_in;
                end else begin
                    stg[s] <= stg[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q_out = stg[STAGES-1];

endmodule

// File: rtl/unl_ref_strobe.sv
module unl_ref_strobe
    import unl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_clk_in,
    output logic strobe
);

    logic       ref_s;
    ref_state_t state_q, state_d;

    unl_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ref_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (ref_clk_in),
        .q_out (ref_s)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= REF_LOW;
        else     state_q <= state_d;
    end

    // Next state: rise and fall transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REF_LOW:  if (ref_s)  state_d = REF_HIGH;
            REF_HIGH: if (!ref_s) state_d = REF_LOW;
        endcase
    end

    // Output: pulse on the rise transition only
    always_comb begin
        strobe = 1'b0;
        unique case (state_q)
            REF_LOW:  strobe = ref_s;
            REF_HIGH: strobe = 1'b0;
        endcase
    end

    // R8: strobe is a single-clock pulse
    a_r8_strobe_single: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);

endmodule

// File: rtl/unl_flag_fsm.sv
module unl_flag_fsm
    import unl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    input  logic unlocked,
    input  logic rd_en,
    output logic flag
);

    flag_state_t state_q, state_d;
    logic        set_req;

    assign set_req = strobe && unlocked;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= FLAG_CLEAR;
        else     state_q <= state_d;
    end

    // Next state: set, clear, hold (set has priority over clear)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR: if (set_req)            state_d = FLAG_SET;
            FLAG_SET:   if (rd_en && !set_req)  state_d = FLAG_CLEAR;
        endcase
    end

    // Output
    always_comb begin
        flag = 1'b0;
        unique case (state_q)
            FLAG_CLEAR: flag = 1'b0;
            FLAG_SET:   flag = 1'b1;
        endcase
    end

    // R2/R3: a strobe seeing an unlocked loop sets the flag
    a_r2_set_on_strobe: assert property (@(posedge clk) disable iff (rst)
        (strobe && unlocked) |=> flag);

    // R4: without a read the flag never drops
    a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag && !rd_en) |=> flag);

    // R5: a read with no concurrent set clears the flag
    a_r5_clear_on_read: assert property (@(posedge clk) disable iff (rst)
        (flag && rd_en && !(strobe && unlocked)) |=> !flag);

    // R7: set and read in the same clock leaves the flag set
    a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
        (rd_en && strobe && unlocked) |=> flag);

    // R8: no strobe, no set
    a_r8_no_set_between: assert property (@(posedge clk) disable iff (rst)
        (!flag && !strobe) |=> !flag);

endmodule

// File: rtl/pll_unlock_monitor.sv
module pll_unlock_monitor #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_clk_in,
    input  logic              up_req_n,
    input  logic              dn_req_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data
);

    localparam int PAD_W = DATA_W - 1;

    logic [1:0] req_s;
    logic       unlocked;
    logic       strobe;
    logic       flag;

    // Requests idle high after reset (locked)
    unl_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_req_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  ({up_req_n, dn_req_n}),
        .q_out (req_s)
    );

    assign unlocked = !(req_s[1] && req_s[0]);

    unl_ref_strobe #(.SYNC_STAGES(SYNC_STAGES)) u_strobe (
        .clk        (clk),
        .rst        (rst),
        .ref_clk_in (ref_clk_in),
        .strobe     (strobe)
    );

    unl_flag_fsm u_flag (
        .clk      (clk),
        .rst      (rst),
        .strobe   (strobe),
        .unlocked (unlocked),
        .rd_en    (rd_en),
        .flag     (flag)
    );

    assign rd_data = rd_en ? {{PAD_W{1'b0}}, flag} : '0;

    // R1: flag is clear in the clock after reset
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (flag == 1'b0));

    // R9: idle bus returns zero
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rd_data == '0));

endmodule

// File: tb/sim_pll_unlock_monitor.sv
module sim_pll_unlock_monitor;

    localparam int CLK_P   = 10;
    localparam int REF_DIV = 16;
    localparam int HALF    = REF_DIV / 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_clk_in = 1'b0;
    logic       up_req_n = 1'b1;
    logic       dn_req_n = 1'b1;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int last_rd = -1000;
    int ref_cnt = REF_DIV - 1;
    bit done  = 1'b0;

    pll_unlock_monitor #(.DATA_W(8), .SYNC_STAGES(2)) u0 (
        .clk        (clk),
        .rst        (rst),
        .ref_clk_in (ref_clk_in),
        .up_req_n   (up_req_n),
        .dn_req_n   (dn_req_n),
        .rd_en      (rd_en),
        .rd_data    (rd_data)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Reference clock in step with clk: rises at the negedge where ref_cnt wraps to 0
    always @(negedge clk) begin
        ref_cnt    <= (ref_cnt == REF_DIV - 1) ? 0 : ref_cnt + 1;
        ref_clk_in <= ((ref_cnt == REF_DIV - 1) ? 0 : ref_cnt + 1) < HALF;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(posedge clk);
    endtask

    // Reads closer than one reference period are invalid: wait them out
    task automatic wait_spacing();
        while (cyc - last_rd < REF_DIV + 2) @(posedge clk);
    endtask

    task automatic do_read(output logic [7:0] v);
        wait_spacing();
        @(negedge clk);
        rd_en = 1'b1;
        #1 v = rd_data;
        @(posedge clk);
        last_rd = cyc;
        @(negedge clk);
        rd_en = 1'b0;
        chk(v[7:1] == 7'd0, "R6 upper bits", int'(v[7:1]), 0);
    endtask

    task automatic wait_rise();
        @(posedge clk);
        while (ref_cnt != 0) @(posedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        do_read(v);
        chk(v == 8'd0, "R1 reset read", int'(v), 0);
    endtask

    task automatic t_up_unlock();
        logic [7:0] v;
        @(negedge clk); up_req_n = 1'b0;
        wait_clks(3 * REF_DIV);
        do_read(v);
        chk(v[0] == 1'b1, "R2 up low sets flag", int'(v[0]), 1);
        @(negedge clk); up_req_n = 1'b1;
        wait_clks(2 * REF_DIV);
        do_read(v);
        chk(v[0] == 1'b0, "R5 cleared after read", int'(v[0]), 0);
    endtask

    task automatic t_dn_unlock();
        logic [7:0] v;
        @(negedge clk); dn_req_n = 1'b0;
        wait_clks(3 * REF_DIV);
        do_read(v);
        chk(v[0] == 1'b1, "R3 dn low sets flag", int'(v[0]), 1);
        @(negedge clk); dn_req_n = 1'b1;
        wait_clks(3 * REF_DIV);
        do_read(v);
        chk(v[0] == 1'b0, "R3 both high no set", int'(v[0]), 0);
    endtask

    task automatic t_sticky();
        logic [7:0] v;
        @(negedge clk); up_req_n = 1'b0; dn_req_n = 1'b0;
        wait_clks(2 * REF_DIV);
        @(negedge clk); up_req_n = 1'b1; dn_req_n = 1'b1;
        wait_clks(4 * REF_DIV);
        @(negedge clk); #1;
        chk(rd_data == 8'd0, "R9 idle bus zero", int'(rd_data), 0);
        do_read(v);
        chk(v[0] == 1'b1, "R4 sticky after relock", int'(v[0]), 1);
        do_read(v);
        chk(v[0] == 1'b0, "R5 second read clear", int'(v[0]), 0);
    endtask

    task automatic t_glitch();
        logic [7:0] v;
        wait_spacing();
        wait_rise();
        wait_clks(HALF - 2);
        @(negedge clk); up_req_n = 1'b0;
        wait_clks(3);
        @(negedge clk); up_req_n = 1'b1;
        wait_clks(3 * REF_DIV);
        do_read(v);
        chk(v[0] == 1'b0, "R8 pulse between strobes ignored", int'(v[0]), 0);
    endtask

    task automatic t_collision();
        logic [7:0] v;
        @(negedge clk); dn_req_n = 1'b0;
        wait_clks(2 * REF_DIV);
        wait_spacing();
        wait_rise();                 // edge P0: first sync flop takes the high level
        @(posedge clk);              // edge P1: strobe high until P2
        @(negedge clk);
        rd_en = 1'b1;
        dn_req_n = 1'b1;             // relock; reaches the sampler after P2
        #1 v = rd_data;
        @(posedge clk);              // edge P2: set and read together
        last_rd = cyc;
        @(negedge clk);
        rd_en = 1'b0;
        chk(v[0] == 1'b1, "R7 collision read value", int'(v[0]), 1);
        wait_clks(2 * REF_DIV);
        do_read(v);
        chk(v[0] == 1'b1, "R7 set wins over clear", int'(v[0]), 1);
        do_read(v);
        chk(v[0] == 1'b0, "R7 later read clear", int'(v[0]), 0);
    endtask

    initial begin
        wait_clks(4);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_up_unlock();
        t_dn_unlock();
        t_sticky();
        t_glitch();
        t_collision();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule